// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block turns a fast core clock into the SCL waveform of an I2C master and into two per-bit timing strobes for the byte engine that sits beside it. A divider input sets the SCL period in core clocks. The divider always acts as an even number. SCL is driven low for half of that period and then released for the other half. A drive strobe marks the core clock, a programmable distance after each SCL falling edge, on which the next output data bit may change. A sample strobe marks the core clock, a programmable distance after SCL is seen high, on which the incoming bit is captured.

The released half of each period is counted only while the sampled line is actually high, so a target that holds SCL low slows the bus instead of being overrun. A stretch that lasts too long, measured in whole SCL periods, raises a one-cycle timeout pulse. After that pulse the generator parks with SCL released until enable is taken away and given back. Byte sequencing, FIFOs and registers belong to the surrounding logic.

Top module: `scl_timing_gen`

## Requirements
- R1: With `en` low (and after reset) `scl_drive_low`, `drive_stb`, `sample_stb` and `tmo_pulse` are 0. The core clock after `en` is seen high starts the first low phase. When `en` is dropped, everything returns to that quiet state on the next clock.
- R2: Let H = `div_cfg[15:1]`. SCL is driven low for exactly H core clocks. When nothing stretches it, SCL is released for exactly H core clocks, so a falling edge follows every 2·H clocks. An odd divider 2N+1 behaves exactly like 2N.
- R3: A divider of 0 or 1 behaves as 2 (H = 1).
- R4: `drive_stb` is high for one core clock, exactly D clocks after the first clock of each low phase, where D is the effective falling-edge delay. It occurs once per SCL period.
- R5: `sample_stb` is high for one core clock, exactly S clocks after the first released clock on which `scl_in` is 1, where S is the effective rising-edge delay. It occurs once per SCL period.
- R6: A delay input larger than H acts as H.
- R7: While SCL is released and `scl_in` reads 0, the high phase does not advance. The next low phase begins H clocks after the first clock on which `scl_in` reads 1.
- R8: Let L = `tmo_limit`, with L non-zero. If `scl_in` stays 0 for L·2·H consecutive released clocks, `tmo_pulse` is high for exactly the last of those clocks. A shorter stretch gives no pulse.
- R9: A `tmo_limit` of 0 disables the timeout: a stretch of any length gives no pulse, and clocking resumes normally once the line is released.
- R10: After `tmo_pulse`, SCL stays released and no strobe or further pulse appears while `en` stays high. Dropping and raising `en` restarts clocking with a low phase.
- R11: A delay input of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable for the SCL generator |
| div_cfg | input | 16 | SCL period in core clocks; bit 0 is ignored |
| fall_dly | input | 16 | Core clocks from SCL falling edge to drive strobe |
| rise_dly | input | 16 | Core clocks from SCL seen high to sample strobe |
| tmo_limit | input | 16 | Stretch limit in SCL periods, 0 disables |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| drive_stb | output | 1 | One-clock strobe to change the output data bit |
| sample_stb | output | 1 | One-clock strobe to capture the input data bit |
| tmo_pulse | output | 1 | One-clock pulse when the stretch timeout expires |

## Verification
The generator runs with even, odd, zero and one dividers, and with delays below, equal to and above half the period, and with zero delays. Comparing the edge and strobe cycles against a reference schedule separates correct even rounding and clamping from off-by-one counting. A target model holds the line low after release in three cases: a long stretch with the timeout disabled, a stretch just short of the limit, and one that never ends. These show that the high phase waits for the real line, that the limit is counted in whole periods, and that the generator stays parked until enable is toggled.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    // Phase of the generated SCL waveform.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_HALT = 2'd3
    } scl_phase_e;

    // Events reported by the phase machine to the strobe and timeout logic.
    typedef struct packed {
        logic fall_evt;    // first core clock of a low phase
        logic rise_evt;    // first released clock with the line seen high
        logic stretching;  // released but line still read low
        logic active;      // generating clocks (low or high phase)
    } scl_events_t;

    localparam int STB_DRIVE  = 0;
    localparam int STB_SAMPLE = 1;
    localparam int STB_COUNT  = 2;

endpackage

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int HW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          tmo_i,
    input  logic [HW-1:0] half_i,
    input  logic          scl_i,
    output logic          drive_low_o,
    output scl_events_t   ev_o
);

    scl_phase_e    st_q, st_d;
    logic [HW-1:0] cnt_q, cnt_d;
    logic          last_w;

    assign last_w = (cnt_q == half_i - 1'b1);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en_i) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else begin
            case (st_q)
                PH_IDLE: begin
                    st_d  = PH_LOW;
                    cnt_d = '0;
                end
                PH_LOW: begin
                    if (last_w) begin
                        st_d  = PH_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmo_i) begin
                        st_d  = PH_HALT;
                        cnt_d = '0;
                    end else if (scl_i) begin
                        if (last_w) begin
                            st_d  = PH_LOW;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d  = PH_HALT;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign drive_low_o      = (st_q == PH_LOW);
    assign ev_o.fall_evt    = (st_q == PH_LOW) && (cnt_q == '0);
    assign ev_o.rise_evt    = (st_q == PH_HIGH) && scl_i && (cnt_q == '0);
    assign ev_o.stretching  = (st_q == PH_HIGH) && !scl_i;
    assign ev_o.active      = (st_q == PH_LOW) || (st_q == PH_HIGH);

    // R1: disabling releases the line on the next clock
    assert_release_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !drive_low_o);

    // R7: a stretched line never lets the low phase start early
    assert_wait_for_line_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && ev_o.stretching) |=> !drive_low_o);

    // R10: a timeout parks the generator
    assert_park_after_timeout_R10: assert property (@(posedge clk) disable iff (rst)
        (en_i && tmo_i) |=> !ev_o.active);

endmodule

// File: rtl/scl_strobe_delay.sv
module scl_strobe_delay #(
    parameter int HW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          evt_i,
    input  logic [HW:0]   dly_i,
    input  logic [HW-1:0] half_i,
    output logic          stb_o
);

    logic [HW-1:0] eff_w;
    logic [HW-1:0] cnt_q;

    // Delay of 0 acts as 1; anything above half the period acts as half.
    always_comb begin
        if (dly_i == '0) begin
            eff_w = {{(HW-1){1'b0}}, 1'b1};
        end else if (dly_i > {1'b0, half_i}) begin
            eff_w = half_i;
        end else begin
            eff_w = dly_i[HW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= eff_w;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stb_o = (cnt_q == {{(HW-1){1'b0}}, 1'b1});

    // R1: no strobe once the generator has stopped
    assert_quiet_when_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !stb_o);

    // R4: a strobe lasts a single core clock
    assert_single_cycle_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (stb_o && !evt_i) |=> !stb_o);

endmodule

// File: rtl/scl_stretch_wdog.sv
module scl_stretch_wdog #(
    parameter int HW = 15,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          stretch_i,
    input  logic [HW-1:0] half_i,
    input  logic [TW-1:0] limit_i,
    output logic          tmo_o
);

    logic [HW:0]   sub_q;
    logic [TW-1:0] per_q;
    logic          sub_last;

    // One SCL period is twice the half period in core clocks.
    assign sub_last = (sub_q == {half_i, 1'b0} - 1'b1);
    assign tmo_o    = en_i && stretch_i && sub_last &&
                      (limit_i != '0) && (per_q == limit_i - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en_i || !stretch_i) begin
            sub_q <= '0;
            per_q <= '0;
        end else if (sub_last) begin
            sub_q <= '0;
            per_q <= per_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // R8: the timeout is a single-cycle pulse
    assert_single_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        tmo_o |=> !tmo_o);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [DIV_W-1:0] fall_dly,
    input  logic [DIV_W-1:0] rise_dly,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             drive_stb,
    output logic             sample_stb,
    output logic             tmo_pulse
);

    localparam int HW = DIV_W - 1;

    logic [HW-1:0]        half_w;
    scl_events_t          ev_w;
    logic                 run_w;
    logic [STB_COUNT-1:0] evt_w;
    logic [STB_COUNT-1:0] stb_w;
    logic [HW:0]          dly_w [STB_COUNT];

    // Bit 0 of the divider is dropped; 0 and 1 act as 2.
    assign half_w = (div_cfg[DIV_W-1:1] == '0) ? {{(HW-1){1'b0}}, 1'b1}
                                               : div_cfg[DIV_W-1:1];

    assign run_w = en && ev_w.active;

    assign evt_w[STB_DRIVE]  = ev_w.fall_evt;
    assign evt_w[STB_SAMPLE] = ev_w.rise_evt;
    assign dly_w[STB_DRIVE]  = fall_dly;
    assign dly_w[STB_SAMPLE] = rise_dly;

    scl_phase_fsm #(.HW(HW)) phase_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .tmo_i       (tmo_pulse),
        .half_i      (half_w),
        .scl_i       (scl_in),
        .drive_low_o (scl_drive_low),
        .ev_o        (ev_w)
    );

    for (genvar g = 0; g < STB_COUNT; g++) begin : g_strobe
        scl_strobe_delay #(.HW(HW)) strobe_i (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run_w),
            .evt_i  (evt_w[g]),
            .dly_i  (dly_w[g]),
            .half_i (half_w),
            .stb_o  (stb_w[g])
        );
    end

    assign drive_stb  = stb_w[STB_DRIVE];
    assign sample_stb = stb_w[STB_SAMPLE];

    scl_stretch_wdog #(.HW(HW), .TW(TMO_W)) wdog_i (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en),
        .stretch_i (ev_w.stretching),
        .half_i    (half_w),
        .limit_i   (tmo_limit),
        .tmo_o     (tmo_pulse)
    );

    // R1: nothing is produced while disabled
    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(drive_stb || sample_stb || tmo_pulse));

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        hold = 1'b0;
    logic [15:0] div_cfg = 16'd10;
    logic [15:0] fall_dly = 16'd1;
    logic [15:0] rise_dly = 16'd1;
    logic [15:0] tmo_limit = 16'd0;
    logic        scl_line;
    logic        scl_drive_low, drive_stb, sample_stb, tmo_pulse;

    // Open-drain line with a target that may hold it low.
    assign scl_line = !scl_drive_low && !hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .en            (en),
        .div_cfg       (div_cfg),
        .fall_dly      (fall_dly),
        .rise_dly      (rise_dly),
        .tmo_limit     (tmo_limit),
        .scl_in        (scl_line),
        .scl_drive_low (scl_drive_low),
        .drive_stb     (drive_stb),
        .sample_stb    (sample_stb),
        .tmo_pulse     (tmo_pulse)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        string req;
    } exp_t;

    exp_t  q_fall[$], q_rel[$], q_drv[$], q_smp[$], q_tmo[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string ctx_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int k, input int at, input string req);
        exp_t e;
        e.at = at;
        e.req = req;
        case (k)
            0: q_fall.push_back(e);
            1: q_rel.push_back(e);
            2: q_drv.push_back(e);
            3: q_smp.push_back(e);
            default: q_tmo.push_back(e);
        endcase
    endtask

    task automatic observe(input int k, input string name);
        exp_t e;
        bit   have = 0;
        case (k)
            0: if (q_fall.size() > 0) begin e = q_fall.pop_front(); have = 1; end
            1: if (q_rel.size() > 0)  begin e = q_rel.pop_front();  have = 1; end
            2: if (q_drv.size() > 0)  begin e = q_drv.pop_front();  have = 1; end
            3: if (q_smp.size() > 0)  begin e = q_smp.pop_front();  have = 1; end
            default: if (q_tmo.size() > 0) begin e = q_tmo.pop_front(); have = 1; end
        endcase
        if (!have)
            check(1'b0, ctx_req, {"unexpected ", name, " at cycle"}, cyc, -1);
        else
            check(e.at == cyc, e.req, {name, " cycle"}, cyc, e.at);
    endtask

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        bit prev_low = 1'b0;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (!rst) begin
                if (scl_drive_low && !prev_low) observe(0, "SCL fall");
                if (!scl_drive_low && prev_low) observe(1, "SCL release");
                if (drive_stb)  observe(2, "drive strobe");
                if (sample_stb) observe(3, "sample strobe");
                if (tmo_pulse)  observe(4, "timeout pulse");
            end
            prev_low = scl_drive_low;
        end
    end

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_queues_empty();
        int total;
        total = q_fall.size() + q_rel.size() + q_drv.size() + q_smp.size() + q_tmo.size();
        check(total == 0, ctx_req, "events still pending", total, 0);
        q_fall.delete(); q_rel.delete(); q_drv.delete(); q_smp.delete(); q_tmo.delete();
    endtask

    // Reference schedule for a run started at c0 and stopped at t_end.
    task automatic expect_run(input int c0, input int h, input int ef, input int er,
                              input int rel, input int t_end,
                              input string r_fall, input string r_drv, input string r_smp);
        int  f = c0 + 1;
        int  r;
        bit  first = 1;
        while (f <= t_end) begin
            push(0, f, r_fall);
            if (f + ef <= t_end) push(2, f + ef, r_drv);
            if (f + h <= t_end) push(1, f + h, "R2");
            else push(1, t_end + 1, "R1");
            r = f + h;
            if (first && rel > r) r = rel;
            first = 0;
            if (r + er <= t_end) push(3, r + er, r_smp);
            f = r + h;
        end
    endtask

    task automatic run_case(input int dv, input int fd, input int rd, input int lim,
                            input int h, input int ef, input int er,
                            input int rel_off, input int len,
                            input string r_fall, input string r_drv, input string r_smp);
        int c0;
        @(negedge clk);
        div_cfg = 16'(dv);
        fall_dly = 16'(fd);
        rise_dly = 16'(rd);
        tmo_limit = 16'(lim);
        hold = (rel_off > 0);
        ctx_req = r_fall;
        c0 = cyc;
        expect_run(c0, h, ef, er, (rel_off > 0) ? c0 + rel_off : 0, c0 + len,
                   r_fall, r_drv, r_smp);
        en = 1'b1;
        if (rel_off > 0) begin
            wait_cyc(c0 + rel_off);
            hold = 1'b0;
        end
        wait_cyc(c0 + len);
        en = 1'b0;
        repeat (4) @(negedge clk);
        expect_queues_empty();
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(scl_drive_low == 1'b0, "R1", "drive low in reset", int'(scl_drive_low), 0);
        check(drive_stb == 1'b0 && sample_stb == 1'b0, "R1", "strobes in reset",
              int'(drive_stb) + int'(sample_stb), 0);
        check(tmo_pulse == 1'b0, "R1", "timeout in reset", int'(tmo_pulse), 0);
        rst = 1'b0;
        // R1: enable low, even with the line held, produces nothing
        ctx_req = "R1";
        hold = 1'b1;
        repeat (20) @(negedge clk);
        hold = 1'b0;
        check(scl_drive_low == 1'b0, "R1", "drive low while disabled", int'(scl_drive_low), 0);

        // R2 R4 R5: even divider, delays inside the half period
        run_case(10, 2, 3, 0, 5, 2, 3, 0, 60, "R2", "R4", "R5");
        // R2: odd divider behaves as the even value below it
        run_case(11, 4, 1, 0, 5, 4, 1, 0, 47, "R2", "R4", "R5");
        // R3 R11 R6: divider 1, zero fall delay, oversize rise delay
        run_case(1, 0, 5, 0, 1, 1, 1, 0, 25, "R3", "R11", "R6");
        // R3: divider 0
        run_case(0, 1, 1, 0, 1, 1, 1, 0, 18, "R3", "R4", "R5");
        // R6 R11: fall delay above half clamps to half, rise delay 0 acts as 1
        run_case(16, 20, 0, 0, 8, 8, 1, 0, 70, "R2", "R6", "R11");
        // R7 R9: long stretch with the timeout disabled
        run_case(8, 1, 2, 0, 4, 1, 2, 305, 340, "R7", "R4", "R9");
        // R8: stretch shorter than the limit gives no pulse
        run_case(6, 1, 1, 3, 3, 1, 1, 14, 40, "R8", "R4", "R7");

        // R8 R10: stretch that never ends
        @(negedge clk);
        div_cfg = 16'd6;
        fall_dly = 16'd1;
        rise_dly = 16'd1;
        tmo_limit = 16'd3;
        hold = 1'b1;
        ctx_req = "R10";
        c0 = cyc;
        push(0, c0 + 1, "R8");
        push(2, c0 + 2, "R4");
        push(1, c0 + 4, "R2");
        push(4, c0 + 4 + 3 * 6 - 1, "R8");
        en = 1'b1;
        wait_cyc(c0 + 24);
        for (int i = 0; i < 4; i++) begin
            check(scl_drive_low == 1'b0, "R10", "drive low after timeout", int'(scl_drive_low), 0);
            repeat (5) @(negedge clk);
        end
        expect_queues_empty();
        en = 1'b0;
        hold = 1'b0;
        repeat (3) @(negedge clk);
        // R10: restart after enable toggle
        run_case(6, 1, 1, 3, 3, 1, 1, 0, 30, "R10", "R4", "R5");

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule